// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescing Unit

This block holds the control and status registers that govern one DMA channel's interrupts. A descriptor engine pulses a completion input once per finished descriptor. The unit counts those completions against a programmable threshold. It also runs an inactivity delay timer, which restarts on every completion. The channel interrupt fires when enough completions have gathered, or when the channel has been quiet for the programmed delay, or when both happen.

Software writes the control register and the status register through two separate write ports. Interrupt flags in the status register are cleared by writing a one to them. The control read-back shows the live completion counter and the live delay count in place of the stored threshold and delay fields. A tick-enable input sets the timer's pace, and the engine's start pulse marks new work for the channel.

Top module: `dma_irq_coalesce`

## Requirements
- R1: After reset, status reads 0x0000_0001 (bit 0 halted, all else zero), control read-back reads 0x0001_0000 (live counter 1, delay count 0), and `irq` is 0.
- R2: Control bits 23:16 hold the threshold. Each `done_i` pulse decrements the completion counter. A pulse that finds the counter at 1 sets status bit 12 and reloads the counter from the threshold.
- R3: A completion with a nonzero delay field (control bits 31:24) restarts the delay timer at the delay value. A completion with a zero delay field leaves the timer's count and state unchanged.
- R4: A running timer decrements once per `tick_i`. The tick that takes it from 1 to 0 sets status bit 13, reloads the completion counter from the threshold, and stops the timer. Further ticks leave the count at 0 until the next completion.
- R5: When `done_i` and `tick_i` come in the same cycle, the completion takes effect and the tick is discarded: the timer restarts, and no delay flag is raised.
- R6: In a status write, a 1 in bits 14:12 clears that flag and a 0 leaves it unchanged. Status bits 1:0 take the written value. A flag event in the same cycle as its clear wins.
- R7: `irq` is 1 when any of status bits 14:12 is set together with the control enable in the same bit position. `irq` is registered, so it follows a flag or enable change one cycle later.
- R8: Control read-back is {live delay count[31:24], live completion counter[23:16], stored control bits 15:0}. Bit 2 shows a pending soft reset.
- R9: A control write with bit 0 set, bit 2 clear, and no soft reset pending clears status bits 1:0 (halted, idle) and loads the completion counter from the newly written threshold.
- R10: A control write with bit 2 set restores the R1 state and stops the timer. Bit 2 reads back as 1 for the following cycle only. A run request written during that cycle is stored but does not start the channel.
- R11: A `start_i` pulse clears the idle bit (status bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write data |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 32 | Status write data |
| done_i | input | 1 | One pulse per completed descriptor |
| start_i | input | 1 | New work posted to the channel |
| tick_i | input | 1 | Delay timer tick enable |
| ctrl_rdata | output | 32 | Control read-back with live counters |
| stat_rdata | output | 32 | Status read-back |
| irq | output | 1 | Channel interrupt, registered |

## Verification
The assertions take the write strobes and pulses to be single-cycle and synchronous. They also take `done_i` and a soft reset write never to arrive in the same cycle, because the soft reset is given priority and the counter checks assume it is absent. The stimulus drives every input on the falling edge and holds it for exactly one cycle. It never combines a soft reset with a completion. Tick and completion are put together only in the deliberate collision case.

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce #(
  parameter int CW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  input  logic        stat_wr,
  input  logic [31:0] stat_wdata,
  input  logic        done_i,
  input  logic        start_i,
  input  logic        tick_i,
  output logic [31:0] ctrl_rdata,
  output logic [31:0] stat_rdata,
  output logic        irq
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [15:0]   ctrl_lo;
  logic [CW-1:0] thr_q, dly_q, cmp_cnt, dly_cnt;
  logic          tmr_run, rst_pend;
  logic [1:0]    stat_lo;
  logic [2:0]    flags;
  logic          irq_q;

  logic srst, run_go, ioc_hit, tmr_hit, tmr_load;

  assign srst     = ctrl_wr && ctrl_wdata[2];
  assign run_go   = ctrl_wr && ctrl_wdata[0] && !ctrl_wdata[2] && !rst_pend;
  assign ioc_hit  = done_i && !srst && !run_go && cmp_cnt == ONE;
  assign tmr_load = done_i && !srst && dly_q != '0;
  assign tmr_hit  = tick_i && tmr_run && dly_cnt == ONE && !done_i && !srst;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      ctrl_lo  <= '0;
      thr_q    <= ONE;
      dly_q    <= '0;
    end else if (ctrl_wr) begin
      ctrl_lo  <= ctrl_wdata[15:0];
      thr_q    <= ctrl_wdata[16 +: CW];
      dly_q    <= ctrl_wdata[24 +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_pend <= 1'b0;
    else        rst_pend <= srst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst)  cmp_cnt <= ONE;
    else if (run_go)     cmp_cnt <= ctrl_wdata[16 +: CW];
    else if (done_i)     cmp_cnt <= (cmp_cnt == ONE) ? thr_q : cmp_cnt - ONE;
    else if (tmr_hit)    cmp_cnt <= thr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      dly_cnt <= '0;
      tmr_run <= 1'b0;
    end else if (tmr_load) begin
      dly_cnt <= dly_q;
      tmr_run <= 1'b1;
    end else if (tick_i && tmr_run && !done_i) begin
      dly_cnt <= dly_cnt - ONE;
      tmr_run <= dly_cnt != ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      stat_lo <= 2'b01;
      flags   <= '0;
    end else begin
      if (run_go)       stat_lo <= 2'b00;
      else if (stat_wr) stat_lo <= {stat_wdata[1] && !start_i, stat_wdata[0]};
      else if (start_i) stat_lo[1] <= 1'b0;
      flags <= (flags & ~(stat_wr ? stat_wdata[14:12] : 3'b000))
             | {1'b0, tmr_hit, ioc_hit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flags & ctrl_lo[14:12]);
  end

  assign irq        = irq_q;
  assign ctrl_rdata = {dly_cnt, cmp_cnt, ctrl_lo[15:3], rst_pend, ctrl_lo[1:0]};
  assign stat_rdata = {17'd0, flags, 10'd0, stat_lo};

  AST_IOC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_hit |=> flags[0] && cmp_cnt == $past(thr_q)); // R2

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_run && !done_i && !srst) |=> $stable(dly_cnt)); // R4

  AST_EXPIRE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_hit |=> !tmr_run && dly_cnt == '0 && flags[1]); // R4

  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && tick_i && tmr_load && !stat_wr) |=> tmr_run && dly_cnt == $past(dly_q)); // R5

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_wdata[13] && !tmr_hit) |=> !flags[1]); // R6

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(flags & ctrl_lo[14:12]) != 3'b000); // R7

  AST_SRST: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> stat_lo == 2'b01 && rst_pend && !tmr_run); // R10

endmodule

// File: tb/test_dma_irq_coalesce.sv
module test_dma_irq_coalesce;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 1'b0, stat_wr = 1'b0, done_i = 1'b0, start_i = 1'b0, tick_i = 1'b0;
  logic [31:0] ctrl_wdata = '0, stat_wdata = '0;
  logic [31:0] ctrl_rdata, stat_rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_irq_coalesce i_dma_irq_coalesce (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .done_i(done_i),
    .start_i(start_i), .tick_i(tick_i), .ctrl_rdata(ctrl_rdata),
    .stat_rdata(stat_rdata), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(bit cw, logic [31:0] cd, bit sw, logic [31:0] sd,
                     bit dn, bit st, bit tk);
    ctrl_wr = cw; ctrl_wdata = cd; stat_wr = sw; stat_wdata = sd;
    done_i = dn; start_i = st; tick_i = tk;
    @(negedge clk);
    ctrl_wr = 0; stat_wr = 0; done_i = 0; start_i = 0; tick_i = 0;
  endtask

  task automatic wr_ctrl(logic [31:0] d); cyc(1, d, 0, 0, 0, 0, 0); endtask
  task automatic wr_stat(logic [31:0] d); cyc(0, 0, 1, d, 0, 0, 0); endtask
  task automatic done1();  cyc(0, 0, 0, 0, 1, 0, 0); endtask
  task automatic tick1();  cyc(0, 0, 0, 0, 0, 0, 1); endtask
  task automatic idle1();  cyc(0, 0, 0, 0, 0, 0, 0); endtask

  task automatic t_reset();
    chk("R1 status", stat_rdata, 32'h0000_0001);
    chk("R1 ctrl", ctrl_rdata, 32'h0001_0000);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_threshold();
    wr_ctrl(32'h0003_1001);
    chk("R9 run clears halted", stat_rdata, 0);
    chk("R8 R9 counter loaded", ctrl_rdata, 32'h0003_1001);
    done1(); done1();
    chk("R2 counted down", ctrl_rdata, 32'h0001_1001);
    chk("R2 no flag yet", stat_rdata, 0);
    done1();
    chk("R2 flag set", stat_rdata, 32'h0000_1000);
    chk("R2 reload", ctrl_rdata, 32'h0003_1001);
    chk("R7 irq not yet", {31'd0, irq}, 0);
    idle1();
    chk("R7 irq raised", {31'd0, irq}, 1);
  endtask

  task automatic t_w1c();
    wr_stat(32'h0000_0000);
    chk("R6 zero keeps flag", stat_rdata, 32'h0000_1000);
    wr_stat(32'h0000_1000);
    chk("R6 one clears flag", stat_rdata, 0);
    chk("R7 irq still registered", {31'd0, irq}, 1);
    idle1();
    chk("R7 irq dropped", {31'd0, irq}, 0);
  endtask

  task automatic t_mask();
    wr_ctrl(32'h0001_0001);
    done1();
    chk("R2 flag with threshold 1", stat_rdata, 32'h0000_1000);
    idle1(); idle1();
    chk("R7 masked irq", {31'd0, irq}, 0);
    wr_ctrl(32'h0001_1001);
    idle1();
    chk("R7 enable raises irq", {31'd0, irq}, 1);
    wr_stat(32'h0000_1000);
  endtask

  task automatic t_delay();
    wr_ctrl(32'h0305_2001);
    done1();
    chk("R3 timer loaded", ctrl_rdata, 32'h0304_2001);
    tick1(); tick1();
    chk("R4 timer decrements", ctrl_rdata, 32'h0104_2001);
    chk("R4 no flag yet", stat_rdata, 0);
    tick1();
    chk("R4 expiry flag", stat_rdata, 32'h0000_2000);
    chk("R4 counter reload", ctrl_rdata, 32'h0005_2001);
    idle1();
    chk("R7 delay irq", {31'd0, irq}, 1);
    tick1(); tick1();
    chk("R4 stays stopped", ctrl_rdata, 32'h0005_2001);
    wr_stat(32'h0000_2000);
    tick1();
    chk("R4 expiry once", stat_rdata, 0);
  endtask

  task automatic t_restart();
    done1(); tick1();
    chk("R3 timer running", ctrl_rdata, 32'h0204_2001);
    done1();
    chk("R3 restart on completion", ctrl_rdata, 32'h0303_2001);
    tick1(); tick1();
    cyc(0, 0, 0, 0, 1, 0, 1);
    chk("R5 completion wins", ctrl_rdata, 32'h0302_2001);
    chk("R5 no delay flag", stat_rdata, 0);
  endtask

  task automatic t_zero_delay();
    wr_ctrl(32'h0004_0001);
    done1();
    chk("R3 zero delay keeps timer", ctrl_rdata, 32'h0303_0001);
    tick1(); tick1(); tick1();
    chk("R4 expiry reloads threshold", ctrl_rdata, 32'h0004_0001);
    chk("R4 flag without enable", stat_rdata, 32'h0000_2000);
    wr_stat(32'h0000_2000);
  endtask

  task automatic t_idle_start();
    wr_stat(32'h0000_0002);
    chk("R6 low bits written", stat_rdata, 32'h0000_0002);
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R11 start clears idle", stat_rdata, 0);
  endtask

  task automatic t_softreset();
    wr_ctrl(32'h0207_3001);
    done1();
    wr_ctrl(32'h0000_0004);
    chk("R10 status restored", stat_rdata, 32'h0000_0001);
    chk("R10 pending shown", ctrl_rdata, 32'h0001_0004);
    wr_ctrl(32'h0003_0001);
    chk("R10 run ignored", stat_rdata, 32'h0000_0001);
    chk("R10 pending cleared", ctrl_rdata, 32'h0001_0001);
    tick1();
    chk("R10 timer stopped", ctrl_rdata, 32'h0001_0001);
    wr_ctrl(32'h0003_0001);
    chk("R9 run after pending", stat_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_w1c();
    t_mask();
    t_delay();
    t_restart();
    t_zero_delay();
    t_idle_start();
    t_softreset();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (10000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule